// File: doc/BRIEF.md
# Multi-Channel Compare-Match Timer

This block is a register-mapped timer holding several independent channels. Every channel owns an up-counter, a compare register and a small control/status register. One shared start register carries a run bit per channel. A running channel advances on each clock where the common count-enable pulse is high. When the counter equals its compare value on such a clock, it restarts from zero, so one period spans compare-plus-one pulses. At the same time it raises a sticky match flag, and it drives an interrupt line if enabled.

Software writes and reads the registers over a simple single-cycle bus with combinational read data. The compare value takes effect at once. A counter write passes through a two-stage synchroniser, so software sees the old value for a short, fixed window and must poll until the new value appears. The match flag is cleared by writing the control register back with the flag bit at zero. A match in the same cycle as a clear keeps the flag set.

Top module: `cmt_timer`

## Requirements
- R1: After reset the start register is 0, every counter reads 0, every compare register reads all ones, every control register reads 0 and all interrupt lines are low.
- R2: The start register sits at address 0x00, and bit i is the run bit of channel i. It reads back as written, and a channel whose bit is 0 keeps its counter value.
- R3: A channel's counter adds one at a rising clock edge only when its run bit and `cnt_tick` are both high at that edge. Otherwise it holds.
- R4: With the match-enable bit (control bit 2) set, a counting edge at which counter equals compare loads the counter with 0 and sets the flag (control bit 0). One period therefore spans compare+1 counting edges.
- R5: With match-enable clear, the counter runs past the compare value, wraps from all ones to 0 and never sets the flag.
- R6: A channel's `irq` bit is high exactly while its flag and its interrupt-enable bit (control bit 1) are both set.
- R7: A control write with bit 0 low clears the flag. A write with bit 0 high leaves it unchanged, so software can never set the flag.
- R8: If a match occurs on the same edge as a control write that clears the flag, the flag is set after that edge.
- R9: A counter write accepted at edge E loads the counter at edge E+2. Reads before then return the old, still counting value.
- R10: A compare write takes effect at the edge that accepts it.
- R11: Channel i's registers sit at 0x10+0x10*i: control at +0x0, counter at +0x4, compare at +0x8. Reads of unmapped addresses return 0.
- R12: Writing 0 to a control register turns off its interrupt and its match function, and clears its flag.
- R13: The counter width is a parameter (16 or 32). The largest compare value is all ones, and the counter wraps modulo 2^width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | Count-enable pulse shared by all channels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Combinational read data for bus_addr |
| irq | output | NCH | Per-channel match interrupt |

## Verification
A wrong count or sync state shows as a counter read that differs from the bench's model within one clock, and a lost or spurious match shows on `irq` in the same cycle the flag changes. Because the model mirrors every register and the synchroniser window, a load one edge early or late is caught at the very next sample. Collisions between a flag clear and a match are staged on purpose, as are wraps at all ones and stops in the middle of a count.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    // address map (byte offsets)
    localparam int unsigned START_OFS  = 0;
    localparam int unsigned SUB_CTRL   = 4'h0;
    localparam int unsigned SUB_CNT    = 4'h4;
    localparam int unsigned SUB_CMP    = 4'h8;
    localparam int unsigned BLK_SHIFT  = 4;
    // control register bit positions
    localparam int unsigned BIT_FLAG   = 0;
    localparam int unsigned BIT_IE     = 1;
    localparam int unsigned BIT_ME     = 2;
    localparam int unsigned CTRL_W     = 3;
    // synchroniser depth for counter writes
    localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/tmr_wsync.sv
module tmr_wsync #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    output logic          load,
    output logic [CW-1:0] load_val
);
    import cmt_pkg::*;

    typedef struct packed {
        logic [CW-1:0]         hold;
        logic [SYNC_DEPTH-1:0] sync;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_DEPTH-2:0], wr};
        if (wr) st_d.hold = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign load     = st_q.sync[SYNC_DEPTH-1];
    assign load_val = st_q.hold;

    // R9
    sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> ##1 load);
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int unsigned CW = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run,
    input  logic                       tick,
    input  logic                       wr_ctrl,
    input  logic                       wr_cnt,
    input  logic                       wr_cmp,
    input  logic [CW-1:0]              wdata,
    output logic [CW-1:0]              cnt,
    output logic [CW-1:0]              cmp,
    output logic [cmt_pkg::CTRL_W-1:0] ctrl,
    output logic                       irq
);
    import cmt_pkg::*;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] cmp;
        logic          flag;
        logic          ie;
        logic          me;
    } st_t;

    st_t           st_d, st_q;
    logic          load;
    logic [CW-1:0] load_val;
    logic          match_now;

    tmr_wsync #(.CW(CW)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_cnt),
        .wdata    (wdata),
        .load     (load),
        .load_val (load_val)
    );

    always_comb begin
        match_now = run && tick && st_q.me && (st_q.cnt == st_q.cmp) && !load;
        st_d      = st_q;
        if (load)
            st_d.cnt = load_val;
        else if (run && tick)
            st_d.cnt = match_now ? '0 : st_q.cnt + 1'b1;
        if (wr_cmp)
            st_d.cmp = wdata;
        if (wr_ctrl) begin
            st_d.ie   = wdata[BIT_IE];
            st_d.me   = wdata[BIT_ME];
            st_d.flag = st_q.flag & wdata[BIT_FLAG];
        end
        if (match_now)
            st_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.cmp  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign cmp  = st_q.cmp;
    assign ctrl = {st_q.me, st_q.ie, st_q.flag};
    assign irq  = st_q.flag && st_q.ie;

    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && !match_now) |=> st_q.cnt == CW'($past(st_q.cnt) + 1'b1));
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run && tick) && !load) |=> $stable(st_q.cnt));
    // R4
    match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_now |=> (st_q.cnt == '0) && st_q.flag);
    // R7
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wdata[BIT_FLAG] && !match_now) |=> !st_q.flag);
    // R9
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> st_q.cnt == $past(load_val));
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer #(
    parameter int unsigned NCH = 2,
    parameter int unsigned CW  = 16,
    parameter int unsigned AW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cnt_tick,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [CW-1:0]  bus_wdata,
    output logic [CW-1:0]  bus_rdata,
    output logic [NCH-1:0] irq
);
    import cmt_pkg::*;

    localparam int unsigned BLKW = AW - BLK_SHIFT;

    typedef struct packed {
        logic [NCH-1:0] run;
    } top_st_t;

    top_st_t             st_d, st_q;
    logic [BLKW-1:0]     blk;
    logic [3:0]          sub;
    logic                wr_start;
    logic [CW-1:0]       cnt_a  [NCH];
    logic [CW-1:0]       cmp_a  [NCH];
    logic [CTRL_W-1:0]   ctrl_a [NCH];

    assign blk      = bus_addr[AW-1:BLK_SHIFT];
    assign sub      = bus_addr[BLK_SHIFT-1:0];
    assign wr_start = bus_wr && (bus_addr == AW'(START_OFS));

    always_comb begin
        st_d = st_q;
        if (wr_start) st_d.run = bus_wdata[NCH-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam logic [BLKW-1:0] MY_BLK = BLKW'(i + 1);
        logic hit;
        assign hit = bus_wr && (blk == MY_BLK);

        tmr_channel #(.CW(CW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (st_q.run[i]),
            .tick    (cnt_tick),
            .wr_ctrl (hit && (sub == 4'(SUB_CTRL))),
            .wr_cnt  (hit && (sub == 4'(SUB_CNT))),
            .wr_cmp  (hit && (sub == 4'(SUB_CMP))),
            .wdata   (bus_wdata),
            .cnt     (cnt_a[i]),
            .cmp     (cmp_a[i]),
            .ctrl    (ctrl_a[i]),
            .irq     (irq[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(START_OFS))
            bus_rdata = CW'(st_q.run);
        for (int i = 0; i < NCH; i++) begin
            if (blk == BLKW'(i + 1)) begin
                if (sub == 4'(SUB_CTRL)) bus_rdata = CW'(ctrl_a[i]);
                if (sub == 4'(SUB_CNT))  bus_rdata = cnt_a[i];
                if (sub == 4'(SUB_CMP))  bus_rdata = cmp_a[i];
            end
        end
    end

    // R2
    start_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> st_q.run == $past(bus_wdata[NCH-1:0]));
endmodule

// File: tb/sim_cmt_timer.sv
`timescale 1ns/1ps
module sim_cmt_timer;
    localparam int NCH = 2;
    localparam int CW  = 16;
    localparam bit [31:0] MASK = 32'h0000_FFFF;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_tick = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [CW-1:0] bus_wdata = '0;
    logic [CW-1:0] bus_rdata;
    logic [NCH-1:0] irq;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    // reference model
    bit [31:0] m_cnt [NCH];
    bit [31:0] m_cmp [NCH];
    bit [31:0] m_pval[NCH];
    bit        m_flag[NCH];
    bit        m_ie  [NCH];
    bit        m_me  [NCH];
    int        m_wait[NCH];
    bit [NCH-1:0] m_run;

    always #5 clk = ~clk;

    cmt_timer #(.NCH(NCH), .CW(CW), .AW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string req, input bit [31:0] act, input bit [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic rd(input bit [7:0] a, output bit [31:0] v);
        bus_wr   = 1'b0;
        bus_addr = a;
        #0.2;
        v = 32'(bus_rdata);
    endtask

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_cnt[i] = 0; m_cmp[i] = MASK; m_pval[i] = 0;
            m_flag[i] = 0; m_ie[i] = 0; m_me[i] = 0; m_wait[i] = 0;
        end
        m_run = '0;
    endtask

    task automatic model_step(input bit wr, input bit [7:0] a, input bit [31:0] d, input bit tk);
        for (int i = 0; i < NCH; i++) begin
            int base = (i + 1) * 16;
            bit ld = (m_wait[i] == 1);
            bit mt = m_run[i] && tk && m_me[i] && (m_cnt[i] == m_cmp[i]) && !ld;
            bit [31:0] ncnt = m_cnt[i];
            if (ld) ncnt = m_pval[i];
            else if (m_run[i] && tk) ncnt = mt ? 0 : ((m_cnt[i] + 1) & MASK);
            if (wr && int'(a) == base + 8) m_cmp[i] = d & MASK;
            if (wr && int'(a) == base) begin
                m_ie[i] = d[1]; m_me[i] = d[2]; m_flag[i] = m_flag[i] & d[0];
            end
            if (mt) m_flag[i] = 1;
            m_cnt[i] = ncnt;
            if (m_wait[i] > 0) m_wait[i]--;
            if (wr && int'(a) == base + 4) begin
                m_wait[i] = 2; m_pval[i] = d & MASK;
            end
        end
        if (wr && a == 8'h00) m_run = d[NCH-1:0];
    endtask

    task automatic compare_all();
        bit [31:0] v;
        rd(8'h00, v); chk("R2 start", v, 32'(m_run));
        for (int i = 0; i < NCH; i++) begin
            bit [7:0] b = 8'((i + 1) * 16);
            rd(b, v);        chk("R7 ctrl", v, {29'b0, m_me[i], m_ie[i], m_flag[i]});
            rd(b + 8'h4, v); chk("R3 counter", v, m_cnt[i]);
            rd(b + 8'h8, v); chk("R10 compare", v, m_cmp[i]);
        end
        chk("R6 irq", 32'(irq), {30'b0, m_flag[1] & m_ie[1], m_flag[0] & m_ie[0]});
    endtask

    task automatic cyc(input bit wr, input bit [7:0] a, input bit [31:0] d, input bit tk);
        bus_wr = wr; bus_addr = a; bus_wdata = d[CW-1:0]; cnt_tick = tk;
        model_step(wr, a, d, tk);
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        compare_all();
    endtask

    task automatic idle(input int n, input bit tk);
        for (int k = 0; k < n; k++) cyc(0, 8'h00, 0, tk);
    endtask

    initial begin
        bit [31:0] v;
        bit [31:0] old;
        bit [7:0]  lf = 8'h5A;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(8'h18, v); chk("R1 compare reset", v, MASK);
        chk("R13 max compare all ones", v, 32'hFFFF);
        rd(8'h14, v); chk("R1 counter reset", v, 0);
        rd(8'h10, v); chk("R1 ctrl reset", v, 0);
        rd(8'h00, v); chk("R1 start reset", v, 0);
        chk("R1 irq reset", 32'(irq), 0);
        compare_all();

        // R4 periodic match on ch0
        cyc(1, 8'h18, 4, 0);
        cyc(1, 8'h10, 6, 0);
        cyc(1, 8'h00, 1, 0);
        idle(14, 1);
        rd(8'h10, v); chk("R4 flag after match", v & 1, 1);
        chk("R6 irq raised", 32'(irq[0]), 1);

        // R7 write-back clear
        cyc(1, 8'h10, 7, 0);
        rd(8'h10, v); chk("R7 write one keeps flag", v & 1, 1);
        cyc(1, 8'h10, 6, 0);
        rd(8'h10, v); chk("R7 write zero clears flag", v & 1, 0);
        chk("R6 irq dropped", 32'(irq[0]), 0);

        // R8 clear collides with match
        for (int k = 0; k < 10 && m_cnt[0] != m_cmp[0]; k++) cyc(0, 8'h00, 0, 1);
        cyc(1, 8'h10, 6, 1);
        rd(8'h10, v); chk("R8 match wins over clear", v & 1, 1);

        // R3 irregular tick pattern and start toggling
        for (int k = 0; k < 60; k++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            if (k == 20) cyc(1, 8'h00, 3, lf[0]);
            else if (k == 40) cyc(1, 8'h00, 1, lf[0]);
            else if (k == 30) cyc(1, 8'h18, 9, lf[0]);
            else cyc(0, 8'h00, 0, lf[0]);
        end

        // R12 ctrl zero disables match and interrupt
        cyc(1, 8'h10, 0, 0);
        idle(20, 1);
        rd(8'h10, v); chk("R12 ctrl cleared", v, 0);
        chk("R12 no irq", 32'(irq[0]), 0);
        rd(8'h14, v); chk("R12 counter passes compare", 32'(v > 9), 1);

        // R9 / R5 counter write sync and wrap on ch1
        cyc(1, 8'h00, 3, 0);
        cyc(1, 8'h20, 0, 0);
        rd(8'h24, old);
        cyc(1, 8'h24, 32'hFFFD, 0);
        rd(8'h24, v); chk("R9 old value after write edge", v, old);
        cyc(0, 8'h00, 0, 0);
        rd(8'h24, v); chk("R9 old value one edge later", v, old);
        cyc(0, 8'h00, 0, 0);
        rd(8'h24, v); chk("R9 new value two edges later", v, 32'hFFFD);
        idle(4, 1);
        rd(8'h24, v); chk("R5 wrap past all ones", v, 1);
        rd(8'h20, v); chk("R5 no flag without match enable", v & 1, 0);

        // R9 write while running
        cyc(1, 8'h24, 32'h0100, 1);
        idle(5, 1);

        // R11 unmapped addresses
        rd(8'h04, v); chk("R11 unmapped 0x04", v, 0);
        rd(8'h1C, v); chk("R11 unmapped 0x1C", v, 0);
        rd(8'h50, v); chk("R11 unmapped 0x50", v, 0);

        // R2 stopping a channel holds its counter
        cyc(1, 8'h00, 2, 0);
        rd(8'h00, v); chk("R2 start readback", v, 2);
        rd(8'h14, old);
        idle(6, 1);
        rd(8'h14, v); chk("R2 stopped counter holds", v, old);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule